// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small, fully associative store of page-table entries that turns a 32-bit virtual address into a physical address for 4 KB pages. Each entry is keyed by a 20-bit virtual page number and the process tag that was current when the entry was written. A lookup matches only entries that carry the current tag. The 12-bit page offset passes through untranslated. Every lookup gets one registered response, which is one of these: a translation, a page fault (the entry exists but its page is not resident), a permission fault, or a miss with a refill request.

On a miss, an external walker or software supplies the entry through the fill port. A fill goes to the slot already holding the same page and tag if there is one. Otherwise it goes to the lowest free slot. When all slots are full, it goes to the slot chosen by a tree pseudo-LRU. Software can remove one page's entry, or empty the whole buffer, for example on a context switch when tags are not used. Changing the process tag leaves the stored entries in place. Each entry keeps a reference bit and a modify bit, and a lookup reports their values as they were before the access.

Top module: `tagged_tlb`

## Requirements
- R1: A lookup whose page and current tag match a resident entry, and whose access is permitted, returns code 1 (hit). The physical address is the entry's physical page number above the unchanged 12-bit offset, and the entry's cacheable flag is also returned.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R3: A lookup with no matching entry returns code 2 (miss) with `refill_req` high and `refill_vpn` equal to the requested page number. `refill_req` is low for every other response.
- R4: A lookup that matches an entry whose present flag is clear returns code 3 (page fault). This takes priority over the permission check.
- R5: Access rights are 2-bit codes: 0 means none, 1 means read only, and 2 or 3 mean read and write. User-mode lookups use the user code and kernel-mode lookups use the kernel code. A read needs a non-zero code and a write needs bit 1 set. A denied access returns code 4 (permission fault).
- R6: `rsp_ref` and `rsp_mod` report the matched entry's reference and modify bits as they were before the lookup. A hit sets the reference bit, and a hit on a write also sets the modify bit. Faults change neither bit. A fill clears both.
- R7: Lookups, fills and invalidates use the process tag most recently loaded through `ctx_wr`. Loading a new tag does not disturb stored entries.
- R8: `flush` empties every slot. A fill in the same cycle as a flush is discarded.
- R9: `inv_valid` removes only the entry that matches `inv_vpn` under the current tag.
- R10: A fill overwrites a resident entry with the same page and tag. Failing that, it takes the lowest-numbered empty slot. Failing that, it takes the pseudo-LRU victim.
- R11: A binary-tree pseudo-LRU with one bit per internal node is updated by every lookup that matches an entry and by every fill. On each node the fill path steers away from the most recently used branch.
- R12: After reset, no response is pending, the current tag is 0, and every lookup misses.
- R13: A response, and any change made by a fill, flush, invalidate or tag load, becomes visible one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_wr | input | 1 | Load a new current process tag |
| ctx_tag | input | 8 | Process tag to load |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Lookup is a write |
| req_user | input | 1 | Lookup is from user mode |
| fill_valid | input | 1 | Write an entry for the current tag |
| fill_vpn | input | 20 | Virtual page number of the filled entry |
| fill_ppn | input | 20 | Physical page number of the filled entry |
| fill_present | input | 1 | Page is resident |
| fill_kacc | input | 2 | Kernel access code |
| fill_uacc | input | 2 | User access code |
| fill_cacheable | input | 1 | Page may be cached |
| inv_valid | input | 1 | Remove one entry |
| inv_vpn | input | 20 | Page whose entry is removed |
| flush | input | 1 | Remove all entries |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | 0 idle, 1 hit, 2 miss, 3 page fault, 4 permission fault |
| rsp_paddr | output | 32 | Translated address on a hit, else 0 |
| rsp_cacheable | output | 1 | Cacheable flag on a hit |
| rsp_ref | output | 1 | Reference bit before the access |
| rsp_mod | output | 1 | Modify bit before the access |
| refill_req | output | 1 | Miss: an entry must be filled |
| refill_vpn | output | 20 | Page number that missed |

## Verification
The bench drives a request on a falling edge. The response is registered on the next rising edge, so the bench reads it on the following falling edge. Fills, flushes, invalidates and tag loads are also applied on one falling edge and take effect at the next rising edge. A lookup driven afterwards therefore observes their effect in the very next cycle. Replacement order is checked by filling a full buffer and finding out which page now misses. The timing of each check is set by these one-cycle latencies.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int PTAG_W = 8;

    typedef enum logic [2:0] {
        RES_IDLE       = 3'd0,
        RES_HIT        = 3'd1,
        RES_MISS       = 3'd2,
        RES_PAGE_FAULT = 3'd3,
        RES_PERM_FAULT = 3'd4
    } res_e;

    typedef struct packed {
        logic              occ;
        logic [VPN_W-1:0]  vpn;
        logic [PTAG_W-1:0] ptag;
    } tlb_key_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             present;
        logic [1:0]       kacc;
        logic [1:0]       uacc;
        logic             cach;
    } tlb_pte_t;

    typedef struct packed {
        tlb_key_t key;
        tlb_pte_t pte;
        logic     refd;
        logic     dirty;
    } tlb_entry_t;

    // Access code: 0 none, 1 read only, 2/3 read and write.
    function automatic logic acc_allows(input logic [1:0] acc, input logic is_wr);
        return is_wr ? acc[1] : (acc != 2'b00);
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  tlb_key_t [N-1:0]  keys,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [PTAG_W-1:0] ptag,
    output logic [N-1:0]      hit_vec,
    output logic [IDX_W-1:0]  hit_idx
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = keys[i].occ && (keys[i].vpn == vpn) && (keys[i].ptag == ptag);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N),
    localparam int NODES = N - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_en,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             b_en,
    input  logic [IDX_W-1:0] b_idx,
    output logic [IDX_W-1:0] victim
);
    logic [NODES-1:0] tree_q, tree_d;

    // Node bit 1 means the colder side is the upper half.
    function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                               input logic [IDX_W-1:0] w);
        logic [NODES-1:0] r;
        logic [IDX_W-1:0] node;
        r = t;
        node = '0;
        for (int l = 0; l < IDX_W; l++) begin
            r[node] = ~w[IDX_W-1-l];
            node = IDX_W'(2 * int'(node) + 1 + int'(w[IDX_W-1-l]));
        end
        return r;
    endfunction

    always_comb begin
        tree_d = tree_q;
        if (a_en) tree_d = touch(tree_d, a_idx);
        if (b_en) tree_d = touch(tree_d, b_idx);
    end

    always_comb begin
        logic [IDX_W-1:0] node;
        node = '0;
        victim = '0;
        for (int l = 0; l < IDX_W; l++) begin
            victim[IDX_W-1-l] = tree_q[node];
            node = IDX_W'(2 * int'(node) + 1 + int'(tree_q[node]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tree_q <= '0;
        else     tree_q <= tree_d;
    end

    // R11
    plru_avoids_recent_chk: assert property (@(posedge clk) disable iff (rst)
        b_en |=> (victim != $past(b_idx)));
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctx_wr,
    input  logic [PTAG_W-1:0] ctx_tag,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_present,
    input  logic [1:0]        fill_kacc,
    input  logic [1:0]        fill_uacc,
    input  logic              fill_cacheable,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_cacheable,
    output logic              rsp_ref,
    output logic              rsp_mod,
    output logic              refill_req,
    output logic [VPN_W-1:0]  refill_vpn
);
    tlb_entry_t [N_ENTRIES-1:0] ent_q;
    tlb_key_t   [N_ENTRIES-1:0] keys;
    logic       [N_ENTRIES-1:0] occ_vec, free_vec;
    logic [PTAG_W-1:0] ctx_q;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_view
        assign keys[i]     = ent_q[i].key;
        assign occ_vec[i]  = ent_q[i].key.occ;
        assign free_vec[i] = ~ent_q[i].key.occ;
    end

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];

    // Three matchers share the key array: lookup, fill, invalidate.
    logic [N_ENTRIES-1:0] lk_vec, fm_vec, iv_vec;
    logic [IDX_W-1:0]     lk_idx, fm_idx, iv_idx;

    tlb_match #(.N(N_ENTRIES)) u_lk_match (
        .keys(keys), .vpn(req_vpn), .ptag(ctx_q), .hit_vec(lk_vec), .hit_idx(lk_idx));
    tlb_match #(.N(N_ENTRIES)) u_fill_match (
        .keys(keys), .vpn(fill_vpn), .ptag(ctx_q), .hit_vec(fm_vec), .hit_idx(fm_idx));
    tlb_match #(.N(N_ENTRIES)) u_inv_match (
        .keys(keys), .vpn(inv_vpn), .ptag(ctx_q), .hit_vec(iv_vec), .hit_idx(iv_idx));

    logic lk_hit, lk_present, lk_allowed, lk_ok;
    res_e lk_code;
    assign lk_hit     = |lk_vec;
    assign lk_present = ent_q[lk_idx].pte.present;
    assign lk_allowed = acc_allows(req_user ? ent_q[lk_idx].pte.uacc : ent_q[lk_idx].pte.kacc,
                                   req_write);
    assign lk_ok      = lk_hit && lk_present && lk_allowed;

    always_comb begin
        if (!lk_hit)          lk_code = RES_MISS;
        else if (!lk_present) lk_code = RES_PAGE_FAULT;
        else if (!lk_allowed) lk_code = RES_PERM_FAULT;
        else                  lk_code = RES_HIT;
    end

    // Fill placement: same key, then lowest free slot, then pseudo-LRU victim.
    logic [IDX_W-1:0] free_idx, victim, fill_idx;
    always_comb begin
        free_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign fill_idx = (|fm_vec) ? fm_idx : ((|free_vec) ? free_idx : victim);

    logic fill_take;
    assign fill_take = fill_valid && !flush;

    tlb_plru #(.N(N_ENTRIES)) u_plru (
        .clk(clk), .rst(rst),
        .a_en(req_valid && lk_hit), .a_idx(lk_idx),
        .b_en(fill_take), .b_idx(fill_idx),
        .victim(victim));

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q         <= '0;
            ctx_q         <= '0;
            rsp_valid     <= 1'b0;
            rsp_code      <= RES_IDLE;
            rsp_paddr     <= '0;
            rsp_cacheable <= 1'b0;
            rsp_ref       <= 1'b0;
            rsp_mod       <= 1'b0;
            refill_req    <= 1'b0;
            refill_vpn    <= '0;
        end else begin
            if (ctx_wr) ctx_q <= ctx_tag;

            rsp_valid     <= req_valid;
            rsp_code      <= req_valid ? lk_code : RES_IDLE;
            rsp_paddr     <= (req_valid && lk_ok) ? {ent_q[lk_idx].pte.ppn, req_off} : '0;
            rsp_cacheable <= req_valid && lk_ok && ent_q[lk_idx].pte.cach;
            rsp_ref       <= req_valid && lk_hit && ent_q[lk_idx].refd;
            rsp_mod       <= req_valid && lk_hit && ent_q[lk_idx].dirty;
            refill_req    <= req_valid && !lk_hit;
            refill_vpn    <= (req_valid && !lk_hit) ? req_vpn : '0;

            if (flush) begin
                for (int i = 0; i < N_ENTRIES; i++) ent_q[i].key.occ <= 1'b0;
            end else begin
                if (req_valid && lk_ok) begin
                    ent_q[lk_idx].refd <= 1'b1;
                    if (req_write) ent_q[lk_idx].dirty <= 1'b1;
                end
                if (inv_valid && (|iv_vec)) ent_q[iv_idx].key.occ <= 1'b0;
                if (fill_valid) begin
                    ent_q[fill_idx].key.occ     <= 1'b1;
                    ent_q[fill_idx].key.vpn     <= fill_vpn;
                    ent_q[fill_idx].key.ptag    <= ctx_q;
                    ent_q[fill_idx].pte.ppn     <= fill_ppn;
                    ent_q[fill_idx].pte.present <= fill_present;
                    ent_q[fill_idx].pte.kacc    <= fill_kacc;
                    ent_q[fill_idx].pte.uacc    <= fill_uacc;
                    ent_q[fill_idx].pte.cach    <= fill_cacheable;
                    ent_q[fill_idx].refd        <= 1'b0;
                    ent_q[fill_idx].dirty       <= 1'b0;
                end
            end
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R3
    refill_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        refill_req |-> (rsp_valid && rsp_code == RES_MISS));
    // R10
    lookup_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec));
    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ_vec == '0));
    // R6
    write_sets_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && lk_ok && !flush && !fill_valid) |=> ent_q[$past(lk_idx)].dirty);
endmodule

// File: tb/tb_tagged_tlb.sv
`timescale 1ns/1ps
module tb_tagged_tlb;
    import tlb_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic ctx_wr = 0;              logic [7:0]  ctx_tag = 0;
    logic req_valid = 0;           logic [31:0] req_vaddr = 0;
    logic req_write = 0;           logic req_user = 0;
    logic fill_valid = 0;          logic [19:0] fill_vpn = 0;
    logic [19:0] fill_ppn = 0;     logic fill_present = 0;
    logic [1:0] fill_kacc = 0;     logic [1:0] fill_uacc = 0;
    logic fill_cacheable = 0;
    logic inv_valid = 0;           logic [19:0] inv_vpn = 0;
    logic flush = 0;
    logic rsp_valid;               logic [2:0] rsp_code;
    logic [31:0] rsp_paddr;        logic rsp_cacheable;
    logic rsp_ref, rsp_mod, refill_req;
    logic [19:0] refill_vpn;

    tagged_tlb dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic wr, input logic usr);
        req_valid = 1; req_vaddr = {vpn, off}; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_user = 0;
    endtask

    task automatic expect_hit(input string req, input logic [19:0] vpn, input logic wr,
                              input logic usr, input logic [19:0] ppn);
        look(vpn, 12'hA5C, wr, usr);
        chk(req, "hit code", rsp_code, RES_HIT);
        chk(req, "paddr", rsp_paddr, {ppn, 12'hA5C});
    endtask

    task automatic expect_code(input string req, input logic [19:0] vpn, input logic wr,
                               input logic usr, input logic [2:0] code);
        look(vpn, 12'h010, wr, usr);
        chk(req, "code", rsp_code, code);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic pres,
                        input logic [1:0] ka, input logic [1:0] ua, input logic cach);
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_present = pres;
        fill_kacc = ka; fill_uacc = ua; fill_cacheable = cach;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic do_flush();
        flush = 1; @(negedge clk); flush = 0;
    endtask

    task automatic do_inv(input logic [19:0] vpn);
        inv_valid = 1; inv_vpn = vpn; @(negedge clk); inv_valid = 0;
    endtask

    task automatic set_ctx(input logic [7:0] t);
        ctx_wr = 1; ctx_tag = t; @(negedge clk); ctx_wr = 0;
    endtask

    task automatic t_reset();
        // R12
        chk("R12", "rsp_valid after reset", rsp_valid, 0);
        chk("R12", "refill_req after reset", refill_req, 0);
        expect_code("R12", 20'h00000, 0, 0, RES_MISS);
    endtask

    task automatic t_basic();
        fill(20'h12345, 20'h54321, 1, 2'd2, 2'd2, 1);
        look(20'h12345, 12'hFED, 0, 1);
        chk("R1", "code", rsp_code, RES_HIT);
        chk("R1", "paddr", rsp_paddr, 32'h54321FED);
        chk("R1", "cacheable", rsp_cacheable, 1);
        chk("R3", "no refill on hit", refill_req, 0);
        chk("R13", "rsp_valid one cycle after", rsp_valid, 1);
        @(negedge clk);
        chk("R2", "rsp_valid idle", rsp_valid, 0);
        look(20'h0BEEF, 12'h000, 0, 0);
        chk("R3", "miss code", rsp_code, RES_MISS);
        chk("R3", "refill_req", refill_req, 1);
        chk("R3", "refill_vpn", refill_vpn, 20'h0BEEF);
        fill(20'h0BEEF, 20'h00777, 1, 2'd2, 2'd2, 0);
        look(20'h0BEEF, 12'h123, 0, 0);
        chk("R13", "fill visible next cycle", rsp_paddr, 32'h00777123);
        chk("R1", "non-cacheable", rsp_cacheable, 0);
    endtask

    task automatic t_faults();
        fill(20'h00400, 20'h00A00, 0, 2'd2, 2'd0, 0);
        expect_code("R4", 20'h00400, 0, 1, RES_PAGE_FAULT);
        expect_code("R4", 20'h00400, 1, 0, RES_PAGE_FAULT);
        fill(20'h00401, 20'h00A01, 1, 2'd2, 2'd0, 0);
        expect_code("R5", 20'h00401, 0, 1, RES_PERM_FAULT);
        expect_hit("R5", 20'h00401, 1, 0, 20'h00A01);
        fill(20'h00402, 20'h00A02, 1, 2'd1, 2'd1, 0);
        expect_code("R5", 20'h00402, 1, 1, RES_PERM_FAULT);
        expect_hit("R5", 20'h00402, 0, 1, 20'h00A02);
        expect_code("R5", 20'h00402, 1, 0, RES_PERM_FAULT);
        fill(20'h00405, 20'h00A05, 1, 2'd0, 2'd3, 0);
        expect_hit("R5", 20'h00405, 1, 1, 20'h00A05);
        expect_code("R5", 20'h00405, 0, 0, RES_PERM_FAULT);
    endtask

    task automatic t_refmod();
        fill(20'h00403, 20'h00B03, 1, 2'd2, 2'd2, 0);
        look(20'h00403, 12'h0, 0, 1);
        chk("R6", "ref before first read", rsp_ref, 0);
        chk("R6", "mod before first read", rsp_mod, 0);
        look(20'h00403, 12'h0, 0, 1);
        chk("R6", "ref after read", rsp_ref, 1);
        chk("R6", "mod after read", rsp_mod, 0);
        look(20'h00403, 12'h0, 1, 1);
        chk("R6", "mod before write", rsp_mod, 0);
        look(20'h00403, 12'h0, 0, 1);
        chk("R6", "mod after write", rsp_mod, 1);
        fill(20'h00404, 20'h00B04, 1, 2'd1, 2'd1, 0);
        expect_code("R6", 20'h00404, 1, 1, RES_PERM_FAULT);
        look(20'h00404, 12'h0, 0, 1);
        chk("R6", "fault left ref clear", rsp_ref, 0);
        chk("R6", "fault left mod clear", rsp_mod, 0);
        fill(20'h00403, 20'h00B13, 1, 2'd2, 2'd2, 0);
        look(20'h00403, 12'h0, 0, 1);
        chk("R6", "refill clears mod", rsp_mod, 0);
    endtask

    task automatic t_tags();
        do_flush();
        set_ctx(8'd1);
        fill(20'h00300, 20'h00011, 1, 2'd2, 2'd2, 0);
        set_ctx(8'd2);
        expect_code("R7", 20'h00300, 0, 0, RES_MISS);
        fill(20'h00300, 20'h00022, 1, 2'd2, 2'd2, 0);
        expect_hit("R7", 20'h00300, 0, 0, 20'h00022);
        set_ctx(8'd1);
        expect_hit("R7", 20'h00300, 0, 0, 20'h00011);
        do_inv(20'h00300);
        expect_code("R9", 20'h00300, 0, 0, RES_MISS);
        set_ctx(8'd2);
        expect_hit("R9", 20'h00300, 0, 0, 20'h00022);
        set_ctx(8'd0);
    endtask

    task automatic t_flush();
        fill(20'h00600, 20'h00060, 1, 2'd2, 2'd2, 0);
        fill(20'h00601, 20'h00061, 1, 2'd2, 2'd2, 0);
        do_flush();
        expect_code("R8", 20'h00600, 0, 0, RES_MISS);
        expect_code("R8", 20'h00601, 0, 0, RES_MISS);
        flush = 1; fill_valid = 1; fill_vpn = 20'h00602; fill_ppn = 20'h00062;
        fill_present = 1; fill_kacc = 2'd2; fill_uacc = 2'd2;
        @(negedge clk);
        flush = 0; fill_valid = 0;
        expect_code("R8", 20'h00602, 0, 0, RES_MISS);
    endtask

    task automatic t_inval();
        fill(20'h00700, 20'h00070, 1, 2'd2, 2'd2, 0);
        fill(20'h00701, 20'h00071, 1, 2'd2, 2'd2, 0);
        do_inv(20'h00700);
        expect_code("R9", 20'h00700, 0, 0, RES_MISS);
        expect_hit("R9", 20'h00701, 0, 0, 20'h00071);
    endtask

    task automatic t_place();
        do_flush();
        for (int i = 0; i < 8; i++) fill(20'h00200 + 20'(i), 20'h00900 + 20'(i), 1, 2'd2, 2'd2, 0);
        do_inv(20'h00205);
        fill(20'h00209, 20'h00909, 1, 2'd2, 2'd2, 0);
        for (int i = 0; i < 8; i++)
            if (i != 5) expect_hit("R10", 20'h00200 + 20'(i), 0, 0, 20'h00900 + 20'(i));
        expect_hit("R10", 20'h00209, 0, 0, 20'h00909);
        fill(20'h00203, 20'h00777, 1, 2'd2, 2'd2, 0);
        expect_hit("R10", 20'h00203, 0, 0, 20'h00777);
        for (int i = 0; i < 8; i++)
            if (i != 5 && i != 3) expect_hit("R10", 20'h00200 + 20'(i), 0, 0, 20'h00900 + 20'(i));
        expect_hit("R10", 20'h00209, 0, 0, 20'h00909);
    endtask

    task automatic t_plru();
        do_flush();
        for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h00800 + 20'(i), 1, 2'd2, 2'd2, 0);
        expect_hit("R11", 20'h00100, 0, 0, 20'h00800);
        fill(20'h00108, 20'h00808, 1, 2'd2, 2'd2, 0);
        // Fills touched slots 0..7, then slot 0 was hit: the coldest leaf is slot 4.
        expect_code("R11", 20'h00104, 0, 0, RES_MISS);
        expect_hit("R11", 20'h00108, 0, 0, 20'h00808);
        expect_hit("R11", 20'h00100, 0, 0, 20'h00800);
        expect_hit("R11", 20'h00105, 0, 0, 20'h00805);
        expect_hit("R11", 20'h00107, 0, 0, 20'h00807);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_faults();
        t_refmod();
        t_tags();
        t_flush();
        t_inval();
        t_place();
        t_plru();
        finish_run();
    end

    initial begin
        #(4 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule